// File: doc/BRIEF.md
# Programming Status Read Responder

This block drives the byte-wide read path of a nonvolatile memory model. When no internal programming cycle is running, a selected read returns the word supplied by the array. While the programming timer reports busy, every read returns a status word built from the last byte the host loaded, instead of array data. In that word the top bit is the inverse of the loaded top bit. The next bit flips once per new read access. The remaining low bits repeat the loaded value. This lets host software detect completion either by comparing the top bit with what it wrote, or by watching for the flipping bit to stop changing.

The block also produces the drive-enable for the bidirectional data bus. It keeps its own copy of the last loaded data byte. A load presented while write protection is active is discarded. Such a load starts no busy period upstream, so neither completion indicator appears.

All interfaces are plain level signals with no handshake. A read cannot be stalled. The result of each clock's inputs appears on the outputs one clock later. Array storage, address decoding and the programming timer are outside this block.

Top module: `prog_status_responder`

## Requirements
- R1: During reset and after it is released, `rd_drive` is 0 and `rd_data` is 0 until a read is selected.
- R2: `rd_drive` is 1 in the cycle after a clock edge that samples both `ce_n` and `oe_n` low. It is 0 in the cycle after an edge that samples either of them high.
- R3: With `busy` low at the sampling edge, a selected read returns `array_data` as sampled at that edge.
- R4: With `busy` high, a selected read returns bit 7 equal to the inverse of bit 7 of the last accepted load.
- R5: With `busy` high, bit 6 is 1 on the first read access of a busy period. It inverts on each later new access and holds steady for as long as one access stays selected.
- R6: With `busy` high, bits 5..0 equal bits 5..0 of the last accepted load. No address is involved: every read location gets the same status word.
- R7: Once `busy` is sampled low, reads return true array data. The next busy period restarts bit 6 at 1 on its first access.
- R8: A load (`ld_stb` high) sampled with `protect` high leaves the stored byte unchanged. Later status words still reflect the earlier accepted load.
- R9: Whenever `rd_drive` is 0, `rd_data` is 0.
- R10: A new access begins on the edge where the both-low condition is first seen after it was absent. This can be caused by `oe_n` falling or by `ce_n` falling while the other is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Programming cycle in progress, from the timer |
| protect | input | 1 | Write protection active; loads are discarded |
| ld_stb | input | 1 | Byte load strobe from the write path |
| ld_data | input | DATA_W | Data of the byte being loaded |
| array_data | input | DATA_W | Stored word for the current read address |
| rd_data | output | DATA_W | Read data toward the bus |
| rd_drive | output | 1 | Bus drive-enable |

## Verification
Every result is due exactly one clock after the rising edge that samples its inputs. This covers the drive-enable, the array word, the status word with its flipping bit, and a change to the stored byte caused by a load. The bench changes inputs only on the falling edge. Its reference model takes the same samples at the rising edge, and it compares the registered outputs at the following falling edge, once per clock. Stimulus is grouped into phases, each tagged with the requirement it targets. Examples are long held accesses to show bit 6 holding still, chip-select re-strobes with output enable held low, and loads attempted under protection.

// File: rtl/srr_pkg.sv
package srr_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } rd_src_e;
endpackage

// File: rtl/srr_access_detect.sv
module srr_access_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  output logic active,
  output logic start
);
  logic active_q;

  assign active = ~ce_n & ~oe_n;
  assign start  = active & ~active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active;
  end
endmodule

// File: rtl/srr_last_byte.sv
module srr_last_byte #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_stb,
  input  logic              protect,
  input  logic [DATA_W-1:0] ld_data,
  output logic [DATA_W-1:0] held_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                  held_q <= '0;
    else if (ld_stb && !protect) held_q <= ld_data;
  end
endmodule

// File: rtl/srr_toggle.sv
module srr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic start,
  output logic tog_now
);
  logic tog_q;

  // Value presented for the current access; cleared outside busy periods
  assign tog_now = busy & (tog_q ^ start);

  always_ff @(posedge clk) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_now;
  end
endmodule

// File: rtl/srr_out_stage.sv
module srr_out_stage
  import srr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_src_e           src,
  input  logic [DATA_W-1:0] array_data,
  input  logic [DATA_W-1:0] held,
  input  logic              tog_now,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] next_w;

  for (genvar b = 0; b < DATA_W; b++) begin : g_status
    if (b == POLL_BIT) begin : g_poll
      assign status_w[b] = ~held[b];
    end else if (b == TOG_BIT) begin : g_tog
      assign status_w[b] = tog_now;
    end else begin : g_copy
      assign status_w[b] = held[b];
    end
  end

  always_comb begin
    unique case (src)
      SRC_ARRAY:  next_w = array_data;
      SRC_STATUS: next_w = status_w;
      default:    next_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_drive <= 1'b0;
    end else begin
      rd_data  <= next_w;
      rd_drive <= (src != SRC_NONE);
    end
  end
endmodule

// File: rtl/prog_status_responder.sv
module prog_status_responder
  import srr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              busy,
  input  logic              protect,
  input  logic              ld_stb,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);
  logic              active;
  logic              start;
  logic              tog_now;
  logic [DATA_W-1:0] last_byte;
  rd_src_e           src;

  srr_access_detect u_acc (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .active(active), .start(start)
  );

  srr_last_byte #(.DATA_W(DATA_W)) u_last (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .protect(protect),
    .ld_data(ld_data), .held_q(last_byte)
  );

  srr_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start(start), .tog_now(tog_now)
  );

  always_comb begin
    if (!active)   src = SRC_NONE;
    else if (busy) src = SRC_STATUS;
    else           src = SRC_ARRAY;
  end

  srr_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .src(src), .array_data(array_data),
    .held(last_byte), .tog_now(tog_now), .rd_data(rd_data), .rd_drive(rd_drive)
  );
endmodule

// File: rtl/srr_checker.sv
module srr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              busy,
  input logic              protect,
  input logic              ld_stb,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] last_byte,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_drive
);
  assert_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ce_n && !oe_n) |-> rd_drive);

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n || oe_n) |-> !rd_drive);

  assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive |-> rd_data == '0);

  assert_idle_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive && !$past(busy) |-> rd_data == $past(array_data));

  assert_poll_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive && $past(busy) |-> rd_data[DATA_W-1] == !$past(last_byte[DATA_W-1]));

  assert_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive && $past(busy) |-> rd_data[DATA_W-3:0] == $past(last_byte[DATA_W-3:0]));

  assert_toggle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive && $past(rd_drive) && $past(busy) && $past(busy, 2)
      |-> rd_data[DATA_W-2] == $past(rd_data[DATA_W-2]));

  assert_protect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_stb && protect) |-> last_byte == $past(last_byte));
endmodule

bind prog_status_responder srr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
  .protect(protect), .ld_stb(ld_stb), .array_data(array_data),
  .last_byte(last_byte), .rd_data(rd_data), .rd_drive(rd_drive)
);

// File: tb/prog_status_responder_test.sv
`timescale 1ns/1ps
module prog_status_responder_test;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, busy = 1'b0, protect = 1'b0, ld_stb = 1'b0;
  logic [DW-1:0] ld_data = '0, array_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_drive;

  int    checks = 0, errors = 0;
  string phase = "R1";
  bit    done = 1'b0;

  // reference model state
  bit            m_prev_act = 0, m_tog = 0;
  logic [DW-1:0] m_last = '0, m_exp_data = '0;
  bit            m_exp_drive = 0;

  always #10 clk = ~clk;

  prog_status_responder #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
    .protect(protect), .ld_stb(ld_stb), .ld_data(ld_data),
    .array_data(array_data), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev_act = 0; m_tog = 0; m_last = '0; m_exp_data = '0; m_exp_drive = 0;
    end else begin
      bit act, st, tn;
      act = !ce_n && !oe_n;
      st  = act && !m_prev_act;
      tn  = busy ? (st ? !m_tog : m_tog) : 1'b0;
      m_tog = tn;
      m_exp_drive = act;
      if (!act)      m_exp_data = '0;
      else if (busy) m_exp_data = {!m_last[7], tn, m_last[5:0]};
      else           m_exp_data = array_data;
      if (ld_stb && !protect) m_last = ld_data;
      m_prev_act = act;
    end
  end

  task automatic check(string req, logic [DW-1:0] act_d, logic act_e,
                       logic [DW-1:0] exp_d, logic exp_e);
    checks++;
    if (act_d !== exp_d || act_e !== exp_e) begin
      errors++;
      $display("FAIL %s: data=%02h drive=%0b expected data=%02h drive=%0b",
               req, act_d, act_e, exp_d, exp_e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) check(phase, rd_data, rd_drive, m_exp_data, m_exp_drive);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [DW-1:0] d, logic prot);
    ld_data = d; protect = prot; ld_stb = 1'b1;
    cyc(1);
    ld_stb = 1'b0; protect = 1'b0;
  endtask

  // one read access through output enable, held for len cycles
  task automatic oe_read(int len);
    oe_n = 1'b0; ce_n = 1'b0;
    cyc(len);
    oe_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    cyc(3);
    phase = "R1";
    check("R1", rd_data, rd_drive, '0, 1'b0);
    rst_n = 1'b1;
    cyc(2);
    check("R1", rd_data, rd_drive, '0, 1'b0);

    phase = "R2";
    oe_n = 1'b0; cyc(2);
    oe_n = 1'b1; ce_n = 1'b0; cyc(2);
    ce_n = 1'b1; cyc(1);

    phase = "R3";
    array_data = 8'h5A; oe_read(2);
    array_data = 8'hA7; oe_n = 1'b0; ce_n = 1'b0; cyc(1);
    array_data = 8'h0F; cyc(1);
    array_data = 8'hFF; cyc(1);
    oe_n = 1'b1; ce_n = 1'b1; cyc(1);

    phase = "R9";
    array_data = 8'hC3; cyc(2);

    phase = "R4";
    load(8'h3C, 1'b0);
    busy = 1'b1;
    oe_read(3);
    phase = "R5";
    oe_read(4); oe_read(1); oe_read(2);
    phase = "R10";
    oe_n = 1'b0;
    ce_n = 1'b0; cyc(2); ce_n = 1'b1; cyc(1);
    ce_n = 1'b0; cyc(2); ce_n = 1'b1; cyc(1);
    ce_n = 1'b0; cyc(1);
    oe_n = 1'b1; ce_n = 1'b1; cyc(1);

    phase = "R6";
    array_data = 8'h11; oe_read(1);
    array_data = 8'hEE; oe_read(1);
    load(8'hC5, 1'b0);
    oe_read(2);

    phase = "R7";
    busy = 1'b0;
    array_data = 8'h96; oe_read(2);
    busy = 1'b1;
    oe_read(1); oe_read(1);
    busy = 1'b0; oe_read(1);

    phase = "R8";
    load(8'h72, 1'b0);
    load(8'h8D, 1'b1);
    busy = 1'b1;
    oe_read(2); oe_read(1);
    busy = 1'b0;
    load(8'hB0, 1'b1);
    busy = 1'b1;
    oe_read(1);
    busy = 1'b0;
    array_data = 8'h44; oe_read(1);
    cyc(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    checks++; errors++;
    $display("FAIL watchdog (%s): run did not end, actual=hung expected=finished", phase);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule